// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block serves host burst reads out of an internal word FIFO. The storage side fills the FIFO one word at a time. The host starts a burst by pulling the active-low output enable low, and paces it with a free-running burst clock. The block runs on its own system clock, which must be at least twice the burst clock rate. It detects the edges of the burst clock internally, so it can choose which burst-clock edge counts as the advancing edge and can delay each data change by half a burst-clock period.

A 16-bit mode register holds all of the burst settings:

| Bit(s) | Field | Meaning |
|---|---|---|
| 0 | enable | turns the burst function on |
| 1 | clock inversion | 0: rising burst-clock edge advances; 1: falling edge advances |
| 2 | hold | 1: every change takes effect on the next opposite edge |
| 7:3 | latency | extra wait edges, 0 to 31 |
| 15:8 | length | burst length in words, minus one |

The count of active edges starts at the first active edge seen while the output enable is low. That edge is edge 1. Call the latency L and the burst length N. The first word is driven after active edge 2+L, so the host captures it on edge 3+L. Words then follow one per active edge until N words have been sent. After that, the data bus is released.

The block has no tristate pad of its own. It drives a data output and a drive-enable output, and a pad ring above it forms the tristate bus. Writes to the storage never take the burst path.

Top module: `burst_rd_ctrl`

## Requirements
- R1: After reset the drive enable, the data output, the mode register readback, the underrun flag and the FIFO-full flag are all 0.
- R2: A register write stores all 16 bits, and a later read returns them unchanged. The fields are: bit 0 enable, bit 1 clock inversion, bit 2 hold, bits 7:3 latency L, bits 15:8 length-minus-one (N = field + 1).
- R3: When hold is 0, the drive enable rises and the first FIFO word appears on the data output in the system-clock cycle after active edge 2+L. The bus is never driven unless the output enable was low in the cycle before.
- R4: Each later active edge presents the next FIFO word, in the order the words were written. The drive enable falls after active edge 3+L+N-1, that is after edge 2+L+N. The data output changes only when a word is launched.
- R5: When clock inversion is 1, falling burst-clock edges are the active edges and rising edges are the opposite edges. When it is 0, the roles are reversed.
- R6: When hold is 1, every launch and the final release due at active edge k happen instead at the first opposite edge after edge k.
- R7: Taking the output enable high drops the drive enable on the next system-clock edge. It also clears the edge count and the underrun flag, so the next burst counts again from edge 1.
- R8: If the FIFO is empty when a word is due, the underrun flag rises, the previous word stays on the data output and nothing is removed from the FIFO.
- R9: When enable is 0, holding the output enable low and toggling the burst clock never drives the bus and never removes a word from the FIFO.
- R10: The FIFO-full flag is high while FIFO_DEPTH words are stored. A fill write made while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | mode register write strobe |
| cfg_wdata | input | 16 | mode register write data |
| cfg_rdata | output | 16 | mode register contents |
| fill_valid | input | 1 | storage side pushes one word into the FIFO |
| fill_data | input | DW | word pushed by the storage side |
| fill_full | output | 1 | FIFO holds FIFO_DEPTH words |
| burst_clk | input | 1 | host burst clock, sampled by clk |
| oe_n | input | 1 | host output enable, active low |
| dq_out | output | DW | burst data toward the host |
| dq_en | output | 1 | drive enable for the data bus |
| underrun | output | 1 | a word was due while the FIFO was empty |

## Verification
The hardest case to reach from the ports is a burst that underruns or is cut off partway through while hold and clock inversion are both set. In that case, the deferred launch and the pending release must be dropped cleanly. The stimulus randomises every mode field and the number of words filled before each burst, often filling fewer words than the burst length. About a third of the bursts are ended after a random number of burst-clock half periods. The following burst then checks that the edge count restarted from edge 1.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  localparam int LAT_W = 5;
  localparam int LEN_W = 8;
  localparam int CNT_W = 10;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic [LAT_W-1:0] lat;
    logic             hold;
    logic             inv;
    logic             en;
  } burst_cfg_t;

  // active-edge number whose launch puts the first word on the bus
  function automatic logic [CNT_W-1:0] first_edge(input logic [LAT_W-1:0] lat);
    return CNT_W'(lat) + CNT_W'(2);
  endfunction

  // active-edge number at which the bus is released
  function automatic logic [CNT_W-1:0] stop_edge(input logic [LAT_W-1:0] lat,
                                                 input logic [LEN_W-1:0] len_m1);
    return CNT_W'(lat) + CNT_W'(len_m1) + CNT_W'(3);
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg import burst_rd_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output burst_cfg_t  cfg,
  output logic [15:0] rd_data
);

  burst_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= burst_cfg_t'(wr_data);
  end

  assign cfg     = cfg_q;
  assign rd_data = 16'(cfg_q);

endmodule

// File: rtl/burst_clk_edge.sv
module burst_clk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic inv,
  output logic act_edge,
  output logic opp_edge
);

  logic bclk_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  assign rise     = bclk & ~bclk_q;
  assign fall     = ~bclk & bclk_q;
  assign act_edge = inv ? fall : rise;
  assign opp_edge = inv ? rise : fall;

endmodule

// File: rtl/burst_word_fifo.sv
module burst_word_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   level;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + (AW+1)'(1);
        2'b01:   level <= level - (AW+1)'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq import burst_rd_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_cfg_t    cfg,
  input  logic          oe_n,
  input  logic          act_edge,
  input  logic          opp_edge,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_pop,
  output logic          launch_evt,
  output logic          stop_evt,
  output logic [DW-1:0] dout,
  output logic          den,
  output logic          underrun
);

  logic             active;
  logic [CNT_W-1:0] cnt, n_next, e_first, e_stop;
  logic             hit_launch, hit_stop;
  logic             pend_launch, pend_stop;

  assign active  = cfg.en & ~oe_n;
  assign e_first = first_edge(cfg.lat);
  assign e_stop  = stop_edge(cfg.lat, cfg.len_m1);
  assign n_next  = cnt + CNT_W'(1);

  assign hit_launch = act_edge && (n_next >= e_first) && (n_next < e_stop);
  assign hit_stop   = act_edge && (n_next == e_stop);

  assign launch_evt = active & (cfg.hold ? (opp_edge & pend_launch) : hit_launch);
  assign stop_evt   = active & (cfg.hold ? (opp_edge & pend_stop)   : hit_stop);
  assign fifo_pop   = launch_evt & ~fifo_empty;

  // active-edge counter, saturating once the release edge is reached
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (!active)                      cnt <= '0;
    else if (act_edge && (cnt < e_stop))   cnt <= n_next;
  end

  // half-cycle deferral of launch and release when hold is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_launch <= 1'b0;
      pend_stop   <= 1'b0;
    end else if (!active || !cfg.hold) begin
      pend_launch <= 1'b0;
      pend_stop   <= 1'b0;
    end else if (act_edge) begin
      pend_launch <= hit_launch;
      pend_stop   <= hit_stop;
    end else if (opp_edge) begin
      pend_launch <= 1'b0;
      pend_stop   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      den      <= 1'b0;
      underrun <= 1'b0;
    end else if (!active) begin
      den      <= 1'b0;
      underrun <= 1'b0;
    end else if (launch_evt) begin
      den <= 1'b1;
      if (!fifo_empty) dout     <= fifo_rdata;
      else             underrun <= 1'b1;
    end else if (stop_evt) begin
      den <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl import burst_rd_pkg::*; #(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic          fill_full,
  input  logic          burst_clk,
  input  logic          oe_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_en,
  output logic          underrun
);

  burst_cfg_t    cfg;
  logic          act_edge, opp_edge;
  logic          fifo_empty, fifo_pop;
  logic [DW-1:0] fifo_rdata;
  logic          launch_evt, stop_evt;
  logic          cfg_en;

  assign cfg_en = cfg.en;

  burst_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg),
    .rd_data (cfg_rdata)
  );

  burst_clk_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (burst_clk),
    .inv      (cfg.inv),
    .act_edge (act_edge),
    .opp_edge (opp_edge)
  );

  burst_word_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fill_valid),
    .wdata (fill_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fill_full)
  );

  burst_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .oe_n       (oe_n),
    .act_edge   (act_edge),
    .opp_edge   (opp_edge),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_pop   (fifo_pop),
    .launch_evt (launch_evt),
    .stop_evt   (stop_evt),
    .dout       (dq_out),
    .den        (dq_en),
    .underrun   (underrun)
  );

endmodule

// File: rtl/burst_rd_ctrl_chk.sv
module burst_rd_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          en,
  input logic          dq_en,
  input logic [DW-1:0] dq_out,
  input logic          launch_evt,
  input logic          fifo_empty,
  input logic          fifo_pop,
  input logic          fill_full,
  input logic          underrun
);

  p_bus_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_en);

  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dq_en);

  p_data_only_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_evt |=> $stable(dq_out));

  p_underrun_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_evt && fifo_empty) |=> underrun);

  p_no_pop_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop);

  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_full && !fifo_pop) |=> fill_full);

  p_drive_needs_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_en) |-> !$past(oe_n));

endmodule

bind burst_rd_ctrl burst_rd_ctrl_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .oe_n       (oe_n),
  .en         (cfg_en),
  .dq_en      (dq_en),
  .dq_out     (dq_out),
  .launch_evt (launch_evt),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .fill_full  (fill_full),
  .underrun   (underrun)
);

// File: tb/burst_rd_ctrl_tb_top.sv
module burst_rd_ctrl_tb_top;

  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          fill_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic          fill_full;
  logic          burst_clk = 1'b0;
  logic          oe_n = 1'b1;
  logic [DW-1:0] dq_out;
  logic          dq_en;
  logic          underrun;

  int unsigned   n_checks = 0;
  int unsigned   n_fail = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] lastw = '0;
  bit            done = 1'b0;

  always #5ns clk = ~clk;

  burst_rd_ctrl #(.DW(DW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .fill_valid (fill_valid),
    .fill_data  (fill_data),
    .fill_full  (fill_full),
    .burst_clk  (burst_clk),
    .oe_n       (oe_n),
    .dq_out     (dq_out),
    .dq_en      (dq_en),
    .underrun   (underrun)
  );

  function automatic int word_start(input int lat);
    return 2 + lat;
  endfunction

  function automatic int word_last(input int lat, input int lenm1);
    return word_start(lat) + lenm1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input bit en, input bit inv, input bit hold,
                           input int lat, input int lenm1);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {8'(lenm1), 5'(lat), hold, inv, en};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_word(input logic [DW-1:0] w);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_data  = w;
    @(negedge clk);
    fill_valid = 1'b0;
    if (mq.size() < DEPTH) mq.push_back(w);
    check("R10 full flag", 32'(fill_full), 32'(mq.size() == DEPTH));
  endtask

  task automatic run_burst(input bit en, input bit inv, input bit hold,
                           input int lat, input int lenm1, input int steps);
    int  n = 0;
    int  m = 0;
    int  m_prev = 0;
    bit  exp_den = 1'b0;
    bit  exp_uf = 1'b0;
    int  fw = word_start(lat);
    int  lw = word_last(lat, lenm1);
    write_cfg(en, inv, hold, lat, lenm1);
    @(negedge clk);
    oe_n = 1'b0;
    @(posedge clk);
    for (int s = 0; s < steps; s++) begin
      bit act_e;
      @(negedge clk);
      burst_clk = ~burst_clk;
      act_e = burst_clk ^ inv;             // R5: edge roles follow inversion bit
      if (act_e) n++;
      if (!hold)      m = n;
      else if (act_e) m = (n > 0) ? n - 1 : 0;   // R6: deferred to opposite edge
      else            m = n;
      if (en && (m != m_prev)) begin
        if (m >= fw && m <= lw) begin
          exp_den = 1'b1;
          if (mq.size() > 0) lastw = mq.pop_front();
          else               exp_uf = 1'b1;
        end else if (m == lw + 1) begin
          exp_den = 1'b0;
        end
      end
      m_prev = m;
      @(posedge clk);
      #1;
      if (!en) check("R9 disabled bus idle", 32'(dq_en), 32'(0));
      else     check("R3 R4 R6 drive enable", 32'(dq_en), 32'(exp_den));
      if (exp_den) check("R4 R8 word value", 32'(dq_out), 32'(lastw));
      check("R8 underrun flag", 32'(underrun), 32'(exp_uf));
    end
    @(negedge clk);
    oe_n = 1'b1;
    @(posedge clk);
    #1;
    check("R7 release on oe high", 32'(dq_en), 32'(0));
    check("R7 underrun cleared", 32'(underrun), 32'(0));
    if (burst_clk) begin
      @(negedge clk);
      burst_clk = 1'b0;
    end
    @(posedge clk);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 dq_en reset", 32'(dq_en), 32'(0));
    check("R1 dq_out reset", 32'(dq_out), 32'(0));
    check("R1 cfg reset", 32'(cfg_rdata), 32'(0));
    check("R1 underrun reset", 32'(underrun), 32'(0));
    check("R1 full reset", 32'(fill_full), 32'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R2 register readback
    write_cfg(1'b1, 1'b0, 1'b1, 21, 8'hA5);
    #1;
    check("R2 readback", 32'(cfg_rdata), 32'({8'hA5, 5'd21, 1'b1, 1'b0, 1'b1}));
    write_cfg(1'b0, 1'b1, 1'b0, 9, 8'h3C);
    #1;
    check("R2 readback", 32'(cfg_rdata), 32'({8'h3C, 5'd9, 1'b0, 1'b1, 1'b0}));

    // R3 R4 four-word burst, latency 0
    for (int i = 0; i < 4; i++) push_word(16'h1100 + 16'(i));
    run_burst(1'b1, 1'b0, 1'b0, 0, 3, 2 * (0 + 3 + 4));

    // R9 disabled: no drive, no pop; the word is then read by an enabled burst
    push_word(16'hBEEF);
    run_burst(1'b0, 1'b0, 1'b0, 0, 0, 12);
    run_burst(1'b1, 1'b0, 1'b0, 2, 0, 2 * (2 + 3 + 1));

    // R5 R6 inverted clock with hold, latency 3
    for (int i = 0; i < 4; i++) push_word(16'h2200 + 16'(i));
    run_burst(1'b1, 1'b1, 1'b1, 3, 3, 2 * (3 + 3 + 5));

    // R8 underrun: empty FIFO, last word repeated
    run_burst(1'b1, 1'b0, 1'b1, 1, 3, 2 * (1 + 3 + 5));

    // R10 fill past full
    for (int i = 0; i < DEPTH + 2; i++) push_word(16'h3300 + 16'(i));
    // R7 abort mid-burst, then a fresh burst restarts counting
    run_burst(1'b1, 1'b0, 1'b0, 1, 7, 7);
    run_burst(1'b1, 1'b1, 1'b0, 0, 7, 2 * (0 + 3 + 9));

    // constrained random mix
    for (int b = 0; b < 60; b++) begin
      bit en   = ($urandom_range(0, 9) != 0);
      bit inv  = 1'($urandom_range(0, 1));
      bit hold = 1'($urandom_range(0, 1));
      int lat  = $urandom_range(0, 6);
      int lm   = $urandom_range(0, 7);
      int np   = $urandom_range(0, DEPTH + 1);
      int full_steps = 2 * (lat + lm + 5);
      int steps = ($urandom_range(0, 2) == 0) ? $urandom_range(1, full_steps) : full_steps;
      for (int k = 0; k < np; k++) push_word(16'($urandom));
      run_burst(en, inv, hold, lat, lm, steps);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule